// File: doc/BRIEF.md
# Bus Error Capture Register

This block keeps the error status word of one node on a shared system bus. The bus interface logic raises single-cycle detect pulses, one wire per error kind. The block turns each pulse into a sticky bit of a 32-bit status register. Software reads that register over a small CSR port and clears bits by writing ones to them. A second CSR word holds the node's error configuration. It carries a lock-on-first-error enable, two timeout-detection disables and two interrupt disables for the correctable-data classes.

The block can lock its status register. Once locked, the register ignores further pulses, so diagnostic software reads the first failure as it was recorded. Two conditions lock it. One is any bit outside the four data-syndrome flags becoming set. The other is any capture at all while lock-on-first-error is enabled. The register unlocks when software clears every bit, or when software drops the lock-on-first-error enable. The lock state is visible on a status output. A level interrupt reports any stored error bit that is not a syndrome flag.

Top module: `buserr_capture`

## Requirements
- R1: With `csr_addr_i` = 0 the read port returns the status register, and with `csr_addr_i` = 1 it returns the configuration register. A pulse on `err_pulse_i[k]` sets status bit k at the next clock edge, and the bit stays set. This applies to k in 0..10 and 16..31 while the register is unlocked.
- R2: A write to address 0 clears each status bit written as 1 and leaves bits written as 0 unchanged. When a pulse and a clear hit the same bit in the same cycle on an unlocked register, the bit ends up set.
- R3: Status bits 11..15 are reserved. They always read 0, whatever the pulses or writes.
- R4: The register locks when a pulse is captured on any non-syndrome bit (0..10, 16..19, 24..31). Captures that touch only syndrome bits 20..23 do not lock it while configuration bit 31 is 0.
- R5: While configuration bit 31 (lock-on-first-error) is 1, any captured pulse locks the register, syndrome bits included.
- R6: While locked, incoming pulses are ignored and the stored bits change only through clearing writes. The pulse that causes the lock is itself captured, together with any others in that same cycle.
- R7: A locked register unlocks in the cycle its contents become all zero.
- R8: A locked register unlocks when a configuration write changes bit 31 from 1 to 0. The stored bits are kept.
- R9: When configuration bit 2 is 1, pulses on bit 3 (bank lock timeout) are discarded. When configuration bit 3 is 1, pulses on bit 31 (data timeout) are discarded.
- R10: `err_irq_o` is 1 exactly when some stored non-syndrome bit is set. Configuration bit 0 removes bit 17 (correctable write data) from that condition, and configuration bit 1 removes bits 18 and 19 (correctable read data).
- R11: The configuration register stores bits 0..3 and 31 as written. All its other bits read 0.
- R12: A synchronous reset clears the status register, the lock state and the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pulse_i | input | 32 | Single-cycle error detect pulses, one per status bit |
| csr_addr_i | input | 1 | CSR word select: 0 status, 1 configuration |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data (clear mask for status) |
| csr_rdata_o | output | 32 | CSR read data of the selected word |
| locked_o | output | 1 | Status register is locked |
| err_irq_o | output | 1 | Error interrupt level |

## Verification
The bench targets the edges of the lock. It sends a pulse in the very cycle that locks the register; a design that gated that pulse would lose the first failure. It clears a locked register while a new pulse arrives; a design that let the pulse in would stay locked with fresh data. It drops lock-on-first-error and checks that the stored bits remain. It also covers captures of syndrome bits alone, which must neither lock the register without the enable nor raise the interrupt. It checks a clear and a set on the same bit, the masked timeout pulses, the reserved bits, and the interrupt disables. A wrong priority or a missing mask in any of these shows up as a wrong register word, lock level or interrupt level.

// File: rtl/buserr_pkg.sv
package buserr_pkg;

    localparam int unsigned REG_W = 32;

    // implemented status bits and the syndrome field
    localparam logic [REG_W-1:0] ERR_IMPL_MASK = 32'hFFFF_07FF;
    localparam logic [REG_W-1:0] SYND_MASK     = 32'h00F0_0000;
    localparam logic [REG_W-1:0] NONSYND_MASK  = ERR_IMPL_MASK & ~SYND_MASK;

    // status bits with configuration-dependent treatment
    localparam int unsigned BIT_LOCK_TMO = 3;
    localparam int unsigned BIT_CWD      = 17;
    localparam int unsigned BIT_CRD_LO   = 18;
    localparam int unsigned BIT_CRD_HI   = 19;
    localparam int unsigned BIT_DATA_TMO = 31;

    // configuration bit positions
    localparam int unsigned CFG_CWD_IRQ_OFF = 0;
    localparam int unsigned CFG_CRD_IRQ_OFF = 1;
    localparam int unsigned CFG_LKTO_OFF    = 2;
    localparam int unsigned CFG_DTO_OFF     = 3;
    localparam int unsigned CFG_LOCK_FIRST  = 31;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CONFIG = 1'b1
    } csr_sel_e;

    typedef struct packed {
        logic lock_first;
        logic dto_off;
        logic lkto_off;
        logic crd_irq_off;
        logic cwd_irq_off;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        cfg_t c;
        c.lock_first  = w[CFG_LOCK_FIRST];
        c.dto_off     = w[CFG_DTO_OFF];
        c.lkto_off    = w[CFG_LKTO_OFF];
        c.crd_irq_off = w[CFG_CRD_IRQ_OFF];
        c.cwd_irq_off = w[CFG_CWD_IRQ_OFF];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CFG_LOCK_FIRST]  = c.lock_first;
        w[CFG_DTO_OFF]     = c.dto_off;
        w[CFG_LKTO_OFF]    = c.lkto_off;
        w[CFG_CRD_IRQ_OFF] = c.crd_irq_off;
        w[CFG_CWD_IRQ_OFF] = c.cwd_irq_off;
        return w;
    endfunction

endpackage

// File: rtl/buserr_cfg_reg.sv
module buserr_cfg_reg
    import buserr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg_o,
    output logic             lock_first_drop_o
);
    cfg_t cfg_q;
    cfg_t cfg_new;

    assign cfg_new = cfg_from_word(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_new;
        end
    end

    // a write that turns the lock enable off releases the lock
    assign lock_first_drop_o = wr_en & cfg_q.lock_first & ~cfg_new.lock_first;
    assign cfg_o = cfg_q;
endmodule

// File: rtl/buserr_pulse_mask.sv
module buserr_pulse_mask
    import buserr_pkg::*;
(
    input  logic [REG_W-1:0] pulse_i,
    input  cfg_t             cfg_i,
    output logic [REG_W-1:0] pulse_o
);
    logic [REG_W-1:0] det_off;

    always_comb begin
        det_off = '0;
        det_off[BIT_LOCK_TMO] = cfg_i.lkto_off;
        det_off[BIT_DATA_TMO] = cfg_i.dto_off;
    end

    assign pulse_o = pulse_i & ERR_IMPL_MASK & ~det_off;
endmodule

// File: rtl/buserr_capture_core.sv
module buserr_capture_core
    import buserr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    input  logic             lock_first_i,
    input  logic             lock_first_drop_i,
    output logic [REG_W-1:0] err_o,
    output logic             locked_o
);
    logic [REG_W-1:0] err_q;
    logic [REG_W-1:0] err_next;
    logic [REG_W-1:0] capture;
    logic             locked_q;
    logic             lock_evt;
    logic             unlock_evt;

    assign capture = locked_q ? '0 : set_i;

    // per-bit sticky update; reserved positions are constant zero
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (ERR_IMPL_MASK[i]) begin : g_impl
            assign err_next[i] = (err_q[i] & ~clr_i[i]) | capture[i];
        end else begin : g_resv
            assign err_next[i] = 1'b0;
        end
    end

    assign lock_evt   = (|(capture & NONSYND_MASK)) | (lock_first_i & (|capture));
    assign unlock_evt = (err_next == '0) | lock_first_drop_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            err_q    <= err_next;
            locked_q <= locked_q ? ~unlock_evt : lock_evt;
        end
    end

    assign err_o    = err_q;
    assign locked_o = locked_q;
endmodule

// File: rtl/buserr_irq.sv
module buserr_irq
    import buserr_pkg::*;
(
    input  logic [REG_W-1:0] err_i,
    input  cfg_t             cfg_i,
    output logic             irq_o
);
    logic [REG_W-1:0] irq_off;

    always_comb begin
        irq_off = '0;
        irq_off[BIT_CWD]    = cfg_i.cwd_irq_off;
        irq_off[BIT_CRD_LO] = cfg_i.crd_irq_off;
        irq_off[BIT_CRD_HI] = cfg_i.crd_irq_off;
    end

    assign irq_o = |(err_i & NONSYND_MASK & ~irq_off);
endmodule

// File: rtl/buserr_capture.sv
module buserr_capture
    import buserr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] err_pulse_i,
    input  logic        csr_addr_i,
    input  logic        csr_wr_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    output logic        locked_o,
    output logic        err_irq_o
);
    csr_sel_e         sel;
    cfg_t             cfg;
    logic             lock_first_drop;
    logic [REG_W-1:0] pulse_ok;
    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] err_q;

    assign sel      = csr_sel_e'(csr_addr_i);
    assign clr_mask = (csr_wr_i && sel == SEL_STATUS) ? csr_wdata_i : '0;

    buserr_cfg_reg u_cfg (
        .clk               (clk),
        .rst               (rst),
        .wr_en             (csr_wr_i && sel == SEL_CONFIG),
        .wdata             (csr_wdata_i),
        .cfg_o             (cfg),
        .lock_first_drop_o (lock_first_drop)
    );

    buserr_pulse_mask u_mask (
        .pulse_i (err_pulse_i),
        .cfg_i   (cfg),
        .pulse_o (pulse_ok)
    );

    buserr_capture_core u_core (
        .clk               (clk),
        .rst               (rst),
        .set_i             (pulse_ok),
        .clr_i             (clr_mask),
        .lock_first_i      (cfg.lock_first),
        .lock_first_drop_i (lock_first_drop),
        .err_o             (err_q),
        .locked_o          (locked_o)
    );

    buserr_irq u_irq (
        .err_i (err_q),
        .cfg_i (cfg),
        .irq_o (err_irq_o)
    );

    assign csr_rdata_o = (sel == SEL_CONFIG) ? cfg_to_word(cfg) : err_q;
endmodule

// File: rtl/buserr_capture_chk.sv
module buserr_capture_chk
    import buserr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] err_pulse_i,
    input logic        csr_addr_i,
    input logic        csr_wr_i,
    input logic [31:0] err_q,
    input logic        locked_o,
    input logic        err_irq_o
);
    localparam logic [31:0] ALWAYS_LOCK = NONSYND_MASK & ~32'h8000_0008;

    // R6: locked contents move only under a clearing write
    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !(csr_wr_i && csr_addr_i == 1'b0)) |=> (err_q == $past(err_q)));

    // R4: an unmaskable non-syndrome pulse on an unlocked register locks it
    p_nonsyn_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (!locked_o && |(err_pulse_i & ALWAYS_LOCK)) |=> locked_o);

    // R7: the lock never outlives an all-zero register
    p_lock_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (err_q != 32'h0));

    // R3: reserved bits stay zero
    p_resv_zero_r3: assert property (@(posedge clk) disable iff (rst)
        err_q[15:11] == 5'h0);

    // R10: syndrome-only contents never interrupt
    p_syn_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((err_q & NONSYND_MASK) == 32'h0) |-> !err_irq_o);

    // R12: reset empties the register and the lock
    p_reset_r12: assert property (@(posedge clk)
        rst |=> (err_q == 32'h0 && !locked_o));
endmodule

bind buserr_capture buserr_capture_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .err_pulse_i (err_pulse_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wr_i    (csr_wr_i),
    .err_q       (err_q),
    .locked_o    (locked_o),
    .err_irq_o   (err_irq_o)
);

// File: tb/buserr_capture_bench.sv
`timescale 1ns/1ps
module buserr_capture_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] err_pulse_i = '0;
    logic        csr_addr_i = 1'b0;
    logic        csr_wr_i = 1'b0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        locked_o;
    logic        err_irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    buserr_capture u_buserr_capture (
        .clk         (clk),
        .rst         (rst),
        .err_pulse_i (err_pulse_i),
        .csr_addr_i  (csr_addr_i),
        .csr_wr_i    (csr_wr_i),
        .csr_wdata_i (csr_wdata_i),
        .csr_rdata_o (csr_rdata_o),
        .locked_o    (locked_o),
        .err_irq_o   (err_irq_o)
    );

    // {pulse, clear mask, expected status, expected lock}; config all zero
    localparam int NV = 12;
    localparam logic [96:0] VEC [NV] = '{
        {32'h0010_0000, 32'h0000_0000, 32'h0010_0000, 1'b0}, // R1 R4 syndrome alone
        {32'h0020_0000, 32'h0000_0000, 32'h0030_0000, 1'b0}, // R1 sticky
        {32'h0000_0000, 32'h0030_0000, 32'h0000_0000, 1'b0}, // R2 clear
        {32'h0000_0002, 32'h0000_0000, 32'h0000_0002, 1'b1}, // R4 lock
        {32'h0001_0000, 32'h0000_0000, 32'h0000_0002, 1'b1}, // R6 ignored
        {32'h8000_0000, 32'h0000_0000, 32'h0000_0002, 1'b1}, // R6 ignored
        {32'h0000_0000, 32'h0000_0002, 32'h0000_0000, 1'b0}, // R7 unlock
        {32'h0000_F800, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R3 reserved
        {32'h0040_0001, 32'h0000_0000, 32'h0040_0001, 1'b1}, // R6 same-cycle capture
        {32'h0000_0000, 32'h0040_0000, 32'h0000_0001, 1'b1}, // R7 partial clear
        {32'h0000_0004, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R7 R6 clear while pulse
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0}  // R1 idle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cyc(input logic [31:0] pulse, input logic wr, input logic addr,
                       input logic [31:0] wd);
        err_pulse_i = pulse;
        csr_wr_i    = wr;
        csr_addr_i  = addr;
        csr_wdata_i = wd;
        step();
        err_pulse_i = '0;
        csr_wr_i    = 1'b0;
        csr_wdata_i = '0;
    endtask

    task automatic rd(input logic addr, output logic [31:0] d);
        csr_addr_i = addr;
        #1;
        d = csr_rdata_o;
    endtask

    task automatic expect_state(input string req, input logic [31:0] e_err,
                                input logic e_lock, input logic e_irq);
        logic [31:0] d;
        rd(1'b0, d);
        chk(req, d, e_err);
        chk(req, {31'h0, locked_o}, {31'h0, e_lock});
        chk(req, {31'h0, err_irq_o}, {31'h0, e_irq});
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        step();
        rst = 1'b0;
        // R12 reset state
        expect_state("R12 reset", 32'h0, 1'b0, 1'b0);
        rd(1'b1, d);
        chk("R12 reset cfg", d, 32'h0);

        foreach (VEC[i]) begin
            cyc(VEC[i][96:65], VEC[i][64:33] != 32'h0, 1'b0, VEC[i][64:33]);
            rd(1'b0, d);
            chk($sformatf("R1 R2 R3 R4 R6 R7 vec%0d status", i), d, VEC[i][32:1]);
            chk($sformatf("R4 R6 R7 vec%0d lock", i), {31'h0, locked_o}, {31'h0, VEC[i][0]});
        end

        // R11 config readback
        cyc(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d);
        chk("R11 cfg bits", d, 32'h8000_000F);
        cyc(32'h0, 1'b1, 1'b1, 32'h8000_0000);

        // R5 lock on syndrome with lock-on-first-error
        cyc(32'h0080_0000, 1'b0, 1'b0, 32'h0);
        expect_state("R5 syndrome locks", 32'h0080_0000, 1'b1, 1'b0);
        cyc(32'h0000_0001, 1'b0, 1'b0, 32'h0);
        expect_state("R6 locked ignores", 32'h0080_0000, 1'b1, 1'b0);
        // R8 drop enable
        cyc(32'h0, 1'b1, 1'b1, 32'h0);
        expect_state("R8 unlock kept bits", 32'h0080_0000, 1'b0, 1'b0);
        cyc(32'h0010_0000, 1'b0, 1'b0, 32'h0);
        expect_state("R4 syndrome no lock", 32'h0090_0000, 1'b0, 1'b0);
        cyc(32'h0, 1'b1, 1'b0, 32'h0090_0000);

        // R9 timeout masks
        cyc(32'h0, 1'b1, 1'b1, 32'h0000_000C);
        cyc(32'h8000_0008, 1'b0, 1'b0, 32'h0);
        expect_state("R9 masked timeouts", 32'h0, 1'b0, 1'b0);
        cyc(32'h0, 1'b1, 1'b1, 32'h0);
        cyc(32'h0000_0008, 1'b0, 1'b0, 32'h0);
        expect_state("R9 R10 lock timeout", 32'h0000_0008, 1'b1, 1'b1);
        cyc(32'h0, 1'b1, 1'b0, 32'h0000_0008);
        cyc(32'h8000_0000, 1'b0, 1'b0, 32'h0);
        expect_state("R9 data timeout", 32'h8000_0000, 1'b1, 1'b1);
        cyc(32'h0, 1'b1, 1'b0, 32'h8000_0000);

        // R10 interrupt disables
        cyc(32'h0, 1'b1, 1'b1, 32'h0000_0001);
        cyc(32'h0002_0000, 1'b0, 1'b0, 32'h0);
        expect_state("R10 cwd irq off", 32'h0002_0000, 1'b1, 1'b0);
        cyc(32'h0, 1'b1, 1'b0, 32'h0002_0000);
        cyc(32'h0, 1'b1, 1'b1, 32'h0000_0002);
        cyc(32'h000C_0000, 1'b0, 1'b0, 32'h0);
        expect_state("R10 crd irq off", 32'h000C_0000, 1'b1, 1'b0);
        cyc(32'h0, 1'b1, 1'b1, 32'h0);
        expect_state("R10 crd irq on", 32'h000C_0000, 1'b1, 1'b1);
        cyc(32'h0, 1'b1, 1'b0, 32'h000C_0000);

        // R2 set wins over clear on the same bit
        cyc(32'h0010_0000, 1'b0, 1'b0, 32'h0);
        cyc(32'h0010_0000, 1'b1, 1'b0, 32'h0010_0000);
        expect_state("R2 set wins", 32'h0010_0000, 1'b0, 1'b0);
        cyc(32'h0, 1'b1, 1'b0, 32'h0010_0000);

        // R12 reset while locked clears everything
        cyc(32'h0, 1'b1, 1'b1, 32'h8000_000F);
        cyc(32'h0000_0001, 1'b0, 1'b0, 32'h0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        expect_state("R12 reset locked", 32'h0, 1'b0, 1'b0);
        rd(1'b1, d);
        chk("R12 cfg cleared", d, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule